// File: doc/BRIEF.md
# Done-Flag Gatherer with Filtered Cross-Domain Clear

This block collects a set of sticky completion flags in a source clock domain. Each flag is raised by a one-cycle strobe on its own bit of `done_set` and stays up until the block clears it. When every flag is up, a source-domain register captures the reduced AND. Only that registered value is carried into an unrelated destination clock domain, so no combinational reduction is ever sampled across the crossing.

On the destination side the aggregate passes through a two-flop synchronizer and then a run-length filter. The filter raises `all_done` only after the synchronized value has been high on `HITS` successive destination edges. `all_done` also serves as the clear request. It returns to the source domain through its own two-flop synchronizer, where a rising-edge detector produces a single one-cycle `clr_pulse`. During that cycle every flag drops at once and the aggregate register falls. A new round then starts from an empty set.

A done strobe that lands in the same source cycle as `clr_pulse` is discarded, because the clear wins. The system integrator must keep the strobes of the next round out of that cycle.

Top module: `dgx_done_gather`

## Requirements
- R1: A 1 on `done_set[i]` for one `src_clk` cycle sets flag i. The flag stays set until a clear, whether bit i is strobed again or not, and other bits do not affect it.
- R2: `all_done` stays 0 while any of the `N_FLAGS` flags is 0.
- R3: Timing of the rise of `all_done`. Call E0 the `src_clk` edge that captures the last missing strobe. The aggregate register rises on the next `src_clk` edge, E1. `all_done` then rises on destination edge number `SYNC_STAGES - 1 + HITS + 1` counted from the first `dst_clk` edge after E1. With the defaults that is the 5th edge.
- R4: Once high, `all_done` stays high until a clear has taken effect. It never pulses more than once per round.
- R5: `clr_pulse` is 1 for exactly one `src_clk` cycle. It rises on the `SYNC_STAGES + 1`-th `src_clk` edge after the `dst_clk` edge that raised `all_done`.
- R6: On the `src_clk` edge where `clr_pulse` is 1, all flags drop together. `all_done` then falls exactly once, on the `SYNC_STAGES + 1`-th `dst_clk` edge after that clearing edge, and stays 0 until every flag has been set again.
- R7: A strobe on `done_set` in the cycle where `clr_pulse` is 1 is lost, because the clear takes priority. Afterwards all flags read as empty.
- R8: While `rst_n` is 0, `all_done` and `clr_pulse` are 0 and all flags are empty.
- R9: One rise of `all_done` produces exactly one `clr_pulse`. The fall of `all_done` produces none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source-domain clock for the flags, the aggregate register and the clear pulse |
| dst_clk | input | 1 | Destination-domain clock for the synchronizer and the filter |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| done_set | input | N_FLAGS | One-cycle set strobes, bit i sets flag i |
| all_done | output | 1 | Filtered all-flags-set indication in the destination domain, also the clear request |
| clr_pulse | output | 1 | One-cycle clear strobe in the source domain |

## Verification
A flag that fails to stick, or a reduction that ignores one bit, shows up directly at `all_done`. Either it never rises in a round where one flag was strobed long ago, or it rises before the last strobe, within a few destination cycles. A filter count or synchronizer depth that is off by one moves the `all_done` edge by one destination period. A broken edge detector moves or repeats `clr_pulse` by a source cycle. Each of these lands at an exactly predicted sample time, so a single round exposes it. A clear that misses some flags, or that does not override a concurrent strobe, leaves flags behind, and `all_done` then re-asserts without the full set of strobes. The bench catches that during the following idle window.

// File: rtl/dgx_pkg.sv
package dgx_pkg;

  // Width of the run counter that must reach hits-1.
  function automatic int run_bits(input int hits);
    return (hits <= 2) ? 1 : $clog2(hits);
  endfunction

  // Count value at which the next high sample completes the run.
  function automatic int run_last(input int hits);
    return (hits < 1) ? 0 : hits - 1;
  endfunction

  // Source edges from a request change to the clear pulse register.
  function automatic int pulse_lag(input int stages);
    return stages + 1;
  endfunction

endpackage

// File: rtl/dgx_flag_bank.sv
module dgx_flag_bank #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic         agg_o
);

  logic [N-1:0] flags_q;
  logic         full_w;
  logic         agg_q;

  // One sticky cell per flag; clear takes priority over set.
  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags_q[i] <= 1'b0;
      else if (clr_i)     flags_q[i] <= 1'b0;
      else if (set_i[i])  flags_q[i] <= 1'b1;
    end
  end

  assign full_w = &flags_q;

  // Registered reduction: the only signal that leaves this domain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     agg_q <= 1'b0;
    else if (clr_i) agg_q <= 1'b0;
    else            agg_q <= full_w;
  end

  assign agg_o = agg_q;

  a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (flags_q == '0) && !agg_q);

  a_r7_clear_beats_set: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && (set_i != '0)) |=> (flags_q == '0));

  a_r2_agg_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    agg_q |-> full_w);

endmodule

// File: rtl/dgx_sync.sv
module dgx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  if (STAGES <= 1) begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= d_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dgx_hit_filter.sv
module dgx_hit_filter #(
  parameter int HITS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  output logic out_o
);

  localparam int RW = dgx_pkg::run_bits(HITS);
  localparam logic [RW-1:0] LAST = RW'(dgx_pkg::run_last(HITS));

  logic out_q;

  if (HITS <= 1) begin : g_direct
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= 1'b0;
      else        out_q <= in_i;
    end
  end else begin : g_run
    logic [RW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q <= '0;
        out_q <= 1'b0;
      end else if (!in_i) begin
        run_q <= '0;
        out_q <= 1'b0;
      end else if (run_q == LAST) begin
        out_q <= 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign out_o = out_q;

  a_r6_drop_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    !in_i |=> !out_q);

  a_r3_rise_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(in_i));

endmodule

// File: rtl/dgx_edge_pulse.sv
module dgx_edge_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic pulse_o
);

  logic lvl_d;
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      lvl_d   <= lvl_i;
      pulse_q <= lvl_i & ~lvl_d;
    end
  end

  assign pulse_o = pulse_q;

  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  a_r9_from_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(lvl_i));

endmodule

// File: rtl/dgx_done_gather.sv
module dgx_done_gather #(
  parameter int N_FLAGS     = 24,
  parameter int HITS        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               src_clk,
  input  logic               dst_clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] done_set,
  output logic               all_done,
  output logic               clr_pulse
);

  logic agg_src;   // registered AND, source domain
  logic agg_dst;   // synchronized aggregate, destination domain
  logic req_dst;   // filtered aggregate / clear request
  logic req_src;   // request back in the source domain
  logic clr_src;   // one-cycle clear

  dgx_flag_bank #(.N(N_FLAGS)) u_bank (
    .clk   (src_clk),
    .rst_n (rst_n),
    .set_i (done_set),
    .clr_i (clr_src),
    .agg_o (agg_src)
  );

  dgx_sync #(.STAGES(SYNC_STAGES)) u_sync_fwd (
    .clk   (dst_clk),
    .rst_n (rst_n),
    .d_i   (agg_src),
    .q_o   (agg_dst)
  );

  dgx_hit_filter #(.HITS(HITS)) u_filter (
    .clk   (dst_clk),
    .rst_n (rst_n),
    .in_i  (agg_dst),
    .out_o (req_dst)
  );

  dgx_sync #(.STAGES(SYNC_STAGES)) u_sync_back (
    .clk   (src_clk),
    .rst_n (rst_n),
    .d_i   (req_dst),
    .q_o   (req_src)
  );

  dgx_edge_pulse u_pulse (
    .clk     (src_clk),
    .rst_n   (rst_n),
    .lvl_i   (req_src),
    .pulse_o (clr_src)
  );

  assign all_done  = req_dst;
  assign clr_pulse = clr_src;

  a_r8_reset_quiet: assert property (@(posedge src_clk)
    !rst_n |-> !clr_pulse);

endmodule

// File: tb/dgx_done_gather_test.sv
module dgx_done_gather_test;

  localparam int N    = 24;
  localparam int HITS = 3;
  localparam int SYNC = 2;
  localparam longint SP = 10;   // src period, edges at 5 + 10k
  localparam longint DP = 14;   // dst period, edges at 2 + 14m

  typedef struct { logic v; longint t; } ev_t;

  logic         src_clk, dst_clk, rst_n;
  logic [N-1:0] done_set;
  logic         all_done, clr_pulse;
  int           n_chk, n_bad;
  bit           mon_on;
  ev_t          q_dst[$];
  ev_t          q_src[$];

  dgx_done_gather #(.N_FLAGS(N), .HITS(HITS), .SYNC_STAGES(SYNC)) uut (
    .src_clk   (src_clk),
    .dst_clk   (dst_clk),
    .rst_n     (rst_n),
    .done_set  (done_set),
    .all_done  (all_done),
    .clr_pulse (clr_pulse)
  );

  initial begin
    src_clk = 1'b0;
    forever #5 src_clk = ~src_clk;
  end

  initial begin
    dst_clk = 1'b0;
    #2 dst_clk = 1'b1;
    forever #7 dst_clk = ~dst_clk;
  end

  task automatic check(input string req, input bit ok, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint nd(input longint t);
    return 2 + DP * ((t - 2) / DP + 1);
  endfunction

  function automatic longint ns(input longint t);
    return 5 + SP * ((t - 5) / SP + 1);
  endfunction

  // Push the expected port events of one round; t = drive time of last strobe.
  task automatic expect_round(input longint t, output longint s3, output longint df);
    longint e1, dr, ec;
    e1 = t + 5 + SP;
    dr = nd(e1) + DP * (SYNC - 1 + HITS);
    q_dst.push_back('{1'b1, dr + 7});
    s3 = ns(dr) + SP * SYNC;
    q_src.push_back('{1'b1, s3 + 5});
    q_src.push_back('{1'b0, s3 + 15});
    ec = s3 + SP;
    df = nd(ec) + DP * SYNC;
    q_dst.push_back('{1'b0, df + 7});
  endtask

  task automatic strobe(input logic [N-1:0] v, output longint t);
    @(negedge src_clk);
    t = longint'($time);
    done_set = v;
    @(negedge src_clk);
    done_set = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge src_clk);
  endtask

  task automatic finish_round(input string req, input longint df);
    while (longint'($time) < df + 7 + 120) @(negedge src_clk);
    check(req, q_dst.size() == 0, "all_done events left", q_dst.size(), 0);
    check(req, q_src.size() == 0, "clr_pulse events left", q_src.size(), 0);
    check("R6", all_done == 1'b0, "all_done after round", all_done, 0);
  endtask

  // Monitor, destination side
  initial begin
    logic prev;
    ev_t  e;
    prev = 1'b0;
    forever begin
      @(negedge dst_clk);
      if (mon_on && all_done !== prev) begin
        if (q_dst.size() == 0)
          check("R4", 1'b0, "unexpected all_done edge at", longint'($time), 0);
        else begin
          e = q_dst.pop_front();
          check(e.v ? "R3" : "R6", e.v === all_done, "all_done edge value", all_done, e.v);
          check(e.v ? "R3" : "R6", e.t == longint'($time), "all_done edge time", longint'($time), e.t);
        end
        prev = all_done;
      end
    end
  end

  // Monitor, source side
  initial begin
    logic prev;
    ev_t  e;
    prev = 1'b0;
    forever begin
      @(negedge src_clk);
      if (mon_on && clr_pulse !== prev) begin
        if (q_src.size() == 0)
          check("R9", 1'b0, "unexpected clr_pulse edge at", longint'($time), 0);
        else begin
          e = q_src.pop_front();
          check("R5", e.v === clr_pulse, "clr_pulse edge value", clr_pulse, e.v);
          check("R5", e.t == longint'($time), "clr_pulse edge time", longint'($time), e.t);
        end
        prev = clr_pulse;
      end
    end
  end

  initial begin
    #(200000 * 10);
    check("watchdog", 1'b0, "run did not finish", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    longint t, s3, df;
    n_chk = 0; n_bad = 0; mon_on = 1'b0;
    rst_n = 1'b0;
    done_set = '0;
    #30;
    // R8: outputs quiet in reset
    check("R8", all_done == 1'b0, "all_done in reset", all_done, 0);
    check("R8", clr_pulse == 1'b0, "clr_pulse in reset", clr_pulse, 0);
    #10 rst_n = 1'b1;
    mon_on = 1'b1;
    idle(20);
    check("R8", all_done == 1'b0, "all_done after reset", all_done, 0);

    // R2 / R1: ascending, one bit per cycle, last bit held back
    for (int i = 0; i < N - 1; i++) strobe(N'(1) << i, t);
    idle(60);
    check("R2", all_done == 1'b0, "all_done with one flag missing", all_done, 0);
    strobe(N'(1) << (N - 1), t);
    expect_round(t, s3, df);
    finish_round("R1", df);

    // All flags in one cycle
    strobe('1, t);
    expect_round(t, s3, df);
    finish_round("R3", df);

    // Descending with repeated strobes on the same bits (R1)
    for (int i = N - 1; i >= 1; i--) begin
      strobe(N'(1) << i, t);
      strobe(N'(1) << i, t);
    end
    idle(30);
    check("R2", all_done == 1'b0, "all_done with bit 0 missing", all_done, 0);
    strobe(N'(1), t);
    expect_round(t, s3, df);
    finish_round("R1", df);

    // Even bits then odd bits
    strobe({(N/2){2'b01}}, t);
    idle(25);
    check("R2", all_done == 1'b0, "all_done with odd bits missing", all_done, 0);
    strobe({(N/2){2'b10}}, t);
    expect_round(t, s3, df);
    finish_round("R9", df);

    // R7: strobes during the clear cycle are lost
    strobe('1, t);
    expect_round(t, s3, df);
    while (longint'($time) < s3 + 5) @(negedge src_clk);
    check("R5", clr_pulse == 1'b1, "clr_pulse at strobe time", clr_pulse, 1);
    done_set = '1;
    @(negedge src_clk);
    done_set = '0;
    finish_round("R7", df);
    idle(60);
    check("R7", all_done == 1'b0, "all_done after lost strobe", all_done, 0);
    for (int i = 0; i < N - 1; i++) strobe(N'(1) << i, t);
    idle(60);
    check("R7", all_done == 1'b0, "flags emptied by clear", all_done, 0);
    strobe(N'(1) << (N - 1), t);
    expect_round(t, s3, df);
    finish_round("R6", df);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule